// File: doc/BRIEF.md
# Generation-Validated Translation Checker

This block keeps cached address translations coherent lazily, at the memory side, without invalidation broadcasts to the cores. Each translation cached in a core's TLB carries a small generation stamp. The checker keeps a page-table store with a physical page and a generation counter for every virtual page. Each change to a page's mapping writes the new physical page and advances that page's generation by one.

Every memory access arrives with the requesting core, the virtual page, the physical page the TLB used and the TLB's stamp. If the stamp equals the page's current generation, the access goes out one cycle later with the physical page it came with. If the stamps differ, the translation is stale. The checker then issues the access with the current physical page one cycle later than usual and flags it as corrected. In the same cycle it sends a refresh message back to the originating core with the fresh mapping and generation. The receiving TLB overwrites a matching entry with this refresh. The input is held off for the single extra cycle a correction takes.

Top module: `gen_xlat_check`

## Requirements
- R1: After reset, virtual page v maps to physical page v with generation 0. `chkReady` is 1 and `memValid`, `fixed` and `refValid` are 0.
- R2: An accepted check whose stamp equals the page's generation gives `memValid`=1 and `fixed`=0 on the next cycle, with `memPpn` equal to the presented physical page and `refValid`=0.
- R3: A mapping update writes the new physical page and raises that page's generation by one modulo 16, so 15 wraps to 0.
- R4: An accepted check whose stamp differs from the page's generation gives `memValid`=0 on the next cycle. One cycle after that it gives `memValid`=1 and `fixed`=1, with `memPpn` equal to the stored physical page.
- R5: In the cycle a corrected access is output, `refValid` is 1. `refCore` and `refVpn` are those of the check, and `refPpn` and `refGen` are the page's current physical page and generation.
- R6: `chkReady` is 0 for exactly the one cycle after a stale check is accepted. A check presented in that cycle is ignored and produces no output.
- R7: When an update and a check for the same page arrive in the same cycle, the update is applied first and the check is compared against the new generation and mapping.
- R8: Stamps are compared for equality only. A stamp that matches after the generation has wrapped is treated as current.
- R9: An update to one page leaves the generation and mapping of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Mapping update strobe |
| updVpn | input | 4 | Virtual page being remapped |
| updPpn | input | 8 | New physical page |
| chkValid | input | 1 | Access check strobe |
| chkCore | input | 3 | Requesting core |
| chkVpn | input | 4 | Virtual page of the access |
| chkPpn | input | 8 | Physical page the TLB used |
| chkGen | input | 4 | Generation stamp from the TLB entry |
| chkReady | output | 1 | High when a check will be accepted |
| memValid | output | 1 | Access issued to memory |
| memPpn | output | 8 | Physical page of the issued access |
| fixed | output | 1 | Issued access was corrected |
| refValid | output | 1 | Refresh message valid |
| refCore | output | 3 | Core to refresh |
| refVpn | output | 4 | Virtual page to refresh |
| refPpn | output | 8 | Fresh physical page |
| refGen | output | 4 | Fresh generation |

## Verification
A current access is due at the first clock edge after it is presented. A stale one shows no output and a low `chkReady` after that first edge, and shows the corrected access and the refresh after the second edge. The bench drives each stimulus at a falling edge and reads results at the falling edge after each rising edge. For stale checks it reads both cycles, so an output that is early or late is caught. One extra idle cycle separates table entries, so no result can be confused with the next one's.

// File: rtl/gvc_pkg.sv
package gvc_pkg;
  typedef struct packed {
    logic cleanIssue;
    logic fixCapture;
    logic fixEmit;
  } gvcStrobes_t;
endpackage

// File: rtl/gvc_pt_store.sv
module gvc_pt_store #(
  parameter int VPN_W = 4,
  parameter int PPN_W = 8,
  parameter int GEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic [VPN_W-1:0] updVpn,
  input  logic [PPN_W-1:0] updPpn,
  input  logic [VPN_W-1:0] rdVpn,
  output logic [PPN_W-1:0] rdPpn,
  output logic [GEN_W-1:0] rdGen
);
  localparam int NUM_PAGES = 1 << VPN_W;

  logic [PPN_W-1:0] ppnMem [NUM_PAGES];
  logic [GEN_W-1:0] genMem [NUM_PAGES];
  logic [GEN_W-1:0] oldGen;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic hit;
    assign hit = updValid && (updVpn == VPN_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ppnMem[g] <= PPN_W'(g);
        genMem[g] <= '0;
      end else if (hit) begin
        ppnMem[g] <= updPpn;
        genMem[g] <= GEN_W'(genMem[g] + 1'b1);
      end
    end
  end

  assign oldGen = genMem[updVpn];

  // Update applied before a same-cycle lookup of the same page.
  always_comb begin
    if (updValid && (updVpn == rdVpn)) begin
      rdPpn = updPpn;
      rdGen = GEN_W'(genMem[rdVpn] + 1'b1);
    end else begin
      rdPpn = ppnMem[rdVpn];
      rdGen = genMem[rdVpn];
    end
  end

  // R3: an update advances the page's generation by exactly one (mod 2^GEN_W)
  p_gen_bump_r3: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> genMem[$past(updVpn)] == GEN_W'($past(oldGen) + 1'b1));
endmodule

// File: rtl/gvc_control.sv
module gvc_control
  import gvc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkValid,
  input  logic        mismatch,
  output logic        chkReady,
  output gvcStrobes_t strobes
);
  logic fixPending;
  logic accept;

  assign chkReady = !fixPending;
  assign accept   = chkValid && chkReady;

  always_comb begin
    strobes.cleanIssue = accept && !mismatch;
    strobes.fixCapture = accept && mismatch;
    strobes.fixEmit    = fixPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) fixPending <= 1'b0;
    else       fixPending <= strobes.fixCapture;
  end

  // R6: the input is held off for one cycle only
  p_stall_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    !chkReady |=> chkReady);
endmodule

// File: rtl/gvc_datapath.sv
module gvc_datapath
  import gvc_pkg::*;
#(
  parameter int VPN_W  = 4,
  parameter int PPN_W  = 8,
  parameter int GEN_W  = 4,
  parameter int CORE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gvcStrobes_t       strobes,
  input  logic [CORE_W-1:0] chkCore,
  input  logic [VPN_W-1:0]  chkVpn,
  input  logic [PPN_W-1:0]  chkPpn,
  input  logic [GEN_W-1:0]  chkGen,
  input  logic [PPN_W-1:0]  freshPpn,
  input  logic [GEN_W-1:0]  freshGen,
  output logic              mismatch,
  output logic              memValid,
  output logic [PPN_W-1:0]  memPpn,
  output logic              fixed,
  output logic              refValid,
  output logic [CORE_W-1:0] refCore,
  output logic [VPN_W-1:0]  refVpn,
  output logic [PPN_W-1:0]  refPpn,
  output logic [GEN_W-1:0]  refGen
);
  logic [CORE_W-1:0] holdCore;
  logic [VPN_W-1:0]  holdVpn;
  logic [PPN_W-1:0]  holdPpn;
  logic [GEN_W-1:0]  holdGen;

  assign mismatch = (chkGen != freshGen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCore <= '0;
      holdVpn  <= '0;
      holdPpn  <= '0;
      holdGen  <= '0;
    end else if (strobes.fixCapture) begin
      holdCore <= chkCore;
      holdVpn  <= chkVpn;
      holdPpn  <= freshPpn;
      holdGen  <= freshGen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memPpn   <= '0;
      fixed    <= 1'b0;
    end else begin
      memValid <= strobes.cleanIssue || strobes.fixEmit;
      fixed    <= strobes.fixEmit;
      if (strobes.cleanIssue)   memPpn <= chkPpn;
      else if (strobes.fixEmit) memPpn <= holdPpn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refValid <= 1'b0;
      refCore  <= '0;
      refVpn   <= '0;
      refPpn   <= '0;
      refGen   <= '0;
    end else begin
      refValid <= strobes.fixEmit;
      if (strobes.fixEmit) begin
        refCore <= holdCore;
        refVpn  <= holdVpn;
        refPpn  <= holdPpn;
        refGen  <= holdGen;
      end
    end
  end

  // R5: a corrected access always carries its refresh with the same page
  p_ref_with_fix_r5: assert property (@(posedge clk) disable iff (!rstN)
    fixed |-> (refValid && memValid && refPpn == memPpn));
endmodule

// File: rtl/gen_xlat_check.sv
module gen_xlat_check
  import gvc_pkg::*;
#(
  parameter int VPN_W  = 4,
  parameter int PPN_W  = 8,
  parameter int GEN_W  = 4,
  parameter int CORE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic [VPN_W-1:0]  updVpn,
  input  logic [PPN_W-1:0]  updPpn,
  input  logic              chkValid,
  input  logic [CORE_W-1:0] chkCore,
  input  logic [VPN_W-1:0]  chkVpn,
  input  logic [PPN_W-1:0]  chkPpn,
  input  logic [GEN_W-1:0]  chkGen,
  output logic              chkReady,
  output logic              memValid,
  output logic [PPN_W-1:0]  memPpn,
  output logic              fixed,
  output logic              refValid,
  output logic [CORE_W-1:0] refCore,
  output logic [VPN_W-1:0]  refVpn,
  output logic [PPN_W-1:0]  refPpn,
  output logic [GEN_W-1:0]  refGen
);
  gvcStrobes_t      strobes;
  logic             mismatch;
  logic [PPN_W-1:0] freshPpn;
  logic [GEN_W-1:0] freshGen;

  gvc_pt_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .GEN_W(GEN_W)) u_store (
    .clk(clk), .rstN(rstN),
    .updValid(updValid), .updVpn(updVpn), .updPpn(updPpn),
    .rdVpn(chkVpn), .rdPpn(freshPpn), .rdGen(freshGen)
  );

  gvc_control u_ctrl (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .mismatch(mismatch),
    .chkReady(chkReady), .strobes(strobes)
  );

  gvc_datapath #(.VPN_W(VPN_W), .PPN_W(PPN_W), .GEN_W(GEN_W), .CORE_W(CORE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .chkCore(chkCore), .chkVpn(chkVpn), .chkPpn(chkPpn), .chkGen(chkGen),
    .freshPpn(freshPpn), .freshGen(freshGen), .mismatch(mismatch),
    .memValid(memValid), .memPpn(memPpn), .fixed(fixed),
    .refValid(refValid), .refCore(refCore), .refVpn(refVpn),
    .refPpn(refPpn), .refGen(refGen)
  );

  // R2: a current stamp is issued next cycle, unchanged and unflagged
  p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkReady && chkGen == freshGen)
      |=> (memValid && !fixed && !refValid && memPpn == $past(chkPpn)));

  // R4: a stale stamp stalls one cycle, then issues a corrected access
  p_stale_fix_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkReady && chkGen != freshGen)
      |=> (!memValid && !chkReady) ##1 (memValid && fixed));
endmodule

// File: tb/sim_gen_xlat_check.sv
`timescale 1ns/1ps
module sim_gen_xlat_check;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updValid = 1'b0;
  logic [3:0] updVpn = '0;
  logic [7:0] updPpn = '0;
  logic       chkValid = 1'b0;
  logic [2:0] chkCore = '0;
  logic [3:0] chkVpn = '0;
  logic [7:0] chkPpn = '0;
  logic [3:0] chkGen = '0;
  logic       chkReady, memValid, fixed, refValid;
  logic [7:0] memPpn, refPpn;
  logic [2:0] refCore;
  logic [3:0] refVpn, refGen;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gen_xlat_check u0 (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updVpn(updVpn), .updPpn(updPpn),
    .chkValid(chkValid), .chkCore(chkCore), .chkVpn(chkVpn), .chkPpn(chkPpn),
    .chkGen(chkGen), .chkReady(chkReady), .memValid(memValid), .memPpn(memPpn),
    .fixed(fixed), .refValid(refValid), .refCore(refCore), .refVpn(refVpn),
    .refPpn(refPpn), .refGen(refGen)
  );

  typedef struct packed {
    logic       upd;
    logic [3:0] uVpn;
    logic [7:0] uPpn;
    logic       chk;
    logic [2:0] core;
    logic [3:0] vpn;
    logic [7:0] ppn;
    logic [3:0] gen;
    logic       expFix;
    logic [7:0] expPpn;
    logic [3:0] expGen;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd1, 4'd3,  8'h03, 4'd0, 1'b0, 8'h03, 4'd0}, // R2 clean
    '{1'b1, 4'd3, 8'h40, 1'b0, 3'd0, 4'd0,  8'h00, 4'd0, 1'b0, 8'h00, 4'd0}, // R3 update only
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd2, 4'd3,  8'h03, 4'd0, 1'b1, 8'h40, 4'd1}, // R4 stale
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd2, 4'd3,  8'h40, 4'd1, 1'b0, 8'h40, 4'd0}, // R2 refreshed
    '{1'b1, 4'd5, 8'h55, 1'b1, 3'd0, 4'd5,  8'h05, 4'd0, 1'b1, 8'h55, 4'd1}, // R7 same cycle
    '{1'b1, 4'd9, 8'h99, 1'b1, 3'd7, 4'd3,  8'h40, 4'd1, 1'b0, 8'h40, 4'd0}, // R9 other page
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd4, 4'd9,  8'h09, 4'd0, 1'b1, 8'h99, 4'd1}, // R4/R5 page 9
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd5, 4'd0,  8'h00, 4'd0, 1'b0, 8'h00, 4'd0}, // R1 identity
    '{1'b0, 4'd0, 8'h00, 1'b1, 3'd6, 4'd15, 8'h0F, 4'd3, 1'b1, 8'h0F, 4'd0}  // R4 stamp ahead
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    updValid = 1'b0;
    chkValid = 1'b0;
  endtask

  task automatic expectClean(input string req, input logic [7:0] ppn);
    check(memValid == 1'b1, req, "memValid", memValid, 1);
    check(fixed == 1'b0, req, "fixed", fixed, 0);
    check(memPpn == ppn, req, "memPpn", memPpn, ppn);
    check(refValid == 1'b0, req, "refValid", refValid, 0);
  endtask

  task automatic expectFix(input string req, input logic [2:0] core, input logic [3:0] vpn,
                           input logic [7:0] ppn, input logic [3:0] gen);
    check(memValid == 1'b1 && fixed == 1'b1, req, "memValid&fixed", {memValid, fixed}, 3);
    check(memPpn == ppn, req, "memPpn", memPpn, ppn);
    check(refValid == 1'b1, "R5", "refValid", refValid, 1);
    check(refCore == core, "R5", "refCore", refCore, core);
    check(refVpn == vpn, "R5", "refVpn", refVpn, vpn);
    check(refPpn == ppn, "R5", "refPpn", refPpn, ppn);
    check(refGen == gen, "R5", "refGen", refGen, gen);
  endtask

  task automatic doUpdate(input logic [3:0] vpn, input logic [7:0] ppn);
    @(negedge clk);
    updValid = 1'b1; updVpn = vpn; updPpn = ppn;
    @(negedge clk);
    clearInputs();
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    updValid = v.upd; updVpn = v.uVpn; updPpn = v.uPpn;
    chkValid = v.chk; chkCore = v.core; chkVpn = v.vpn; chkPpn = v.ppn; chkGen = v.gen;
    @(negedge clk);
    clearInputs();
    if (!v.chk) begin
      check(memValid == 1'b0, "R3", "memValid idle", memValid, 0);
    end else if (!v.expFix) begin
      expectClean("R2", v.expPpn);
    end else begin
      check(memValid == 1'b0, "R4", "memValid stall", memValid, 0);
      check(chkReady == 1'b0, "R6", "chkReady stall", chkReady, 0);
      @(negedge clk);
      expectFix("R4", v.core, v.vpn, v.expPpn, v.expGen);
    end
    @(negedge clk);
    check(memValid == 1'b0, "R2", "memValid gap", memValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(chkReady == 1'b1, "R1", "chkReady", chkReady, 1);
    check(memValid == 1'b0, "R1", "memValid", memValid, 0);
    check(fixed == 1'b0, "R1", "fixed", fixed, 0);
    check(refValid == 1'b0, "R1", "refValid", refValid, 0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R6: a check offered during the stall cycle is ignored
    @(negedge clk);
    chkValid = 1'b1; chkCore = 3'd1; chkVpn = 4'd3; chkPpn = 8'h03; chkGen = 4'd0;
    @(negedge clk);
    check(chkReady == 1'b0, "R6", "chkReady", chkReady, 0);
    chkCore = 3'd2; chkVpn = 4'd0; chkPpn = 8'h00; chkGen = 4'd0;
    @(negedge clk);
    chkValid = 1'b0;
    expectFix("R4", 3'd1, 4'd3, 8'h40, 4'd1);
    check(chkReady == 1'b1, "R6", "chkReady after", chkReady, 1);
    @(negedge clk);
    check(memValid == 1'b0, "R6", "ignored check output", memValid, 0);

    // R3/R8: generation wraps on page 7
    for (int k = 0; k < 15; k++) doUpdate(4'd7, 8'h77);
    runVec('{1'b0, 4'd0, 8'h00, 1'b1, 3'd3, 4'd7, 8'h77, 4'd15, 1'b0, 8'h77, 4'd0});
    doUpdate(4'd7, 8'h7A);
    runVec('{1'b0, 4'd0, 8'h00, 1'b1, 3'd3, 4'd7, 8'h77, 4'd15, 1'b1, 8'h7A, 4'd0});
    // R8: stamp 0 is current again after the wrap
    runVec('{1'b0, 4'd0, 8'h00, 1'b1, 3'd3, 4'd7, 8'h7A, 4'd0, 1'b0, 8'h7A, 4'd0});

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule